// File: doc/BRIEF.md
# Decibel-Linear Digital Pixel Gain

This block applies a programmable digital gain to a stream of unsigned 12-bit pixel samples. The gain is set by a 10-bit code and is linear in decibels: every code step adds 1/32 dB, so code 0 gives -6 dB, code 192 gives unity and code 1023 gives about +26 dB. The code arrives as two parts, a 4-bit upper field and a 6-bit lower field, which the block joins into one value.

The code is split into a number of whole 6 dB steps, which becomes a binary shift, and a remainder inside one 6 dB step, which selects a 16-bit mantissa from a table computed when the design is elaborated. Gain is applied around a black level. The black level is subtracted first, the difference is scaled, and the black level is added back. Black therefore stays where it is whatever the gain, and a black-level loop placed in front of this stage sees no change when the gain moves. The result is clipped into the 12-bit range.

The gain code and the black level are taken into the block only on cycles that carry no sample. Every pixel of a run of back-to-back samples therefore sees one consistent setting.

Top module: `dgain_db`

## Requirements
- R1: For a captured code c and black level b, with q = c div 192, r = c mod 192 and M = round(32768 * 2^(r/192)), a sample p produces b + floor((p - b) * M * 2^q / 65536) before clipping. The floor rounds toward minus infinity.
- R2: Code 192 is unity gain: the output equals the input sample for any black level.
- R3: A sample equal to the captured black level comes out unchanged at every code, including 0 and 1023.
- R4: A result above 4095 is clipped to 4095 and never wraps.
- R5: A result below 0 is clipped to 0 and never wraps.
- R6: A sample with inValid high at rising edge k appears on outPixel with outValid high after edge k+1. outValid is low after edge k. outPixel holds its value while outValid is low.
- R7: gainHi, gainLo and blackLevel are captured only at rising edges where inValid is low. Changes made while inValid is high have no effect on the samples of that run.
- R8: After a synchronous reset (rst high), outValid is 0 and outPixel is 0. The captured code is 192 and the captured black level is 128.
- R9: The code is {gainHi, gainLo}: gainHi holds bits 9..6 and gainLo holds bits 5..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a pixel on inPixel |
| inPixel | input | 12 | Unsigned pixel sample |
| blackLevel | input | 12 | Black level to hold fixed |
| gainHi | input | 4 | Upper four bits of the gain code |
| gainLo | input | 6 | Lower six bits of the gain code |
| outValid | output | 1 | Marks a result on outPixel |
| outPixel | output | 12 | Gained, clipped straight-binary pixel |

## Verification
The bench builds the block with its default widths: a 12-bit pixel, a 10-bit code, 192 codes per 6 dB and a 16-bit mantissa. With these values every code from 0 to 1023 can be reached, so shifts 0 to 5 and all 192 mantissa entries are exercised. These widths also make both clipping limits reachable: code 1023 drives any difference of more than about 200 LSB past the range. A behavioural model that uses real-valued exponentiation and wide integers predicts every cycle under a random stream. Directed samples check unity, -6 dB, fixed black, both clip limits and code changes made in the middle of a run of samples.

// File: rtl/dgain_pkg.sv
package dgain_pkg;
  localparam int DATA_W    = 12;
  localparam int HI_W      = 4;
  localparam int LO_W      = 6;
  localparam int CODE_W    = HI_W + LO_W;
  localparam int STEP      = 192;
  localparam int MANT_W    = 16;
  localparam int IDX_W     = $clog2(STEP);
  localparam int MAX_Q     = ((1 << CODE_W) - 1) / STEP;
  localparam int SHIFT_W   = $clog2(MAX_Q + 1);
  localparam int UNITY     = STEP;
  localparam int RST_BLACK = 128;

  typedef struct packed {
    logic                load;
    logic                emit;
    logic [SHIFT_W-1:0]  shiftAmt;
    logic [IDX_W-1:0]    mantIdx;
    logic [DATA_W-1:0]   black;
  } dgCtrl_t;
endpackage

// File: rtl/dgain_ctrl.sv
module dgain_ctrl
  import dgain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [HI_W-1:0]   gainHi,
  input  logic [LO_W-1:0]   gainLo,
  input  logic [DATA_W-1:0] blackLevel,
  output dgCtrl_t           ctl
);
  localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(UNITY);

  logic [CODE_W-1:0]  newCode;
  logic [SHIFT_W-1:0] capQ;
  logic [IDX_W-1:0]   capR;
  logic [DATA_W-1:0]  capBlack;
  logic               stage1Valid;

  assign newCode = {gainHi, gainLo};

  // capture only in gaps between samples; the divide sits off the pixel path
  always_ff @(posedge clk) begin
    if (rst) begin
      capQ     <= SHIFT_W'(RESET_CODE / CODE_W'(STEP));
      capR     <= IDX_W'(RESET_CODE % CODE_W'(STEP));
      capBlack <= DATA_W'(RST_BLACK);
    end else if (!inValid) begin
      capQ     <= SHIFT_W'(newCode / CODE_W'(STEP));
      capR     <= IDX_W'(newCode % CODE_W'(STEP));
      capBlack <= blackLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage1Valid <= 1'b0;
    else     stage1Valid <= inValid;
  end

  always_comb begin
    ctl.load     = inValid;
    ctl.emit     = stage1Valid;
    ctl.shiftAmt = capQ;
    ctl.mantIdx  = capR;
    ctl.black    = capBlack;
  end

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ($stable(capQ) && $stable(capR) && $stable(capBlack)));
endmodule

// File: rtl/dgain_datapath.sv
module dgain_datapath
  import dgain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inPixel,
  input  dgCtrl_t           ctl,
  output logic              outValid,
  output logic [DATA_W-1:0] outPixel
);
  localparam int DIFF_W  = DATA_W + 1;
  localparam int PROD_W  = DIFF_W + MANT_W + 1;
  localparam int WIDE_W  = PROD_W + (1 << SHIFT_W);
  localparam real ONE_Q  = 2.0 ** (MANT_W - 1);
  localparam logic signed [WIDE_W-1:0] TOP_VAL = WIDE_W'((1 << DATA_W) - 1);

  logic [MANT_W-1:0] mantRom [STEP];

  for (genvar g = 0; g < STEP; g++) begin : g_mant
    localparam real EXPV = 2.0 ** (real'(g) / real'(STEP));
    localparam int  MV   = $rtoi(EXPV * ONE_Q + 0.5);
    assign mantRom[g] = MANT_W'(MV);
  end

  logic signed [DIFF_W-1:0] diffR;
  logic [MANT_W-1:0]        mantR;
  logic [SHIFT_W-1:0]       shiftR;
  logic [DATA_W-1:0]        blackR;

  always_ff @(posedge clk) begin
    if (rst) begin
      diffR  <= '0;
      mantR  <= '0;
      shiftR <= '0;
      blackR <= '0;
    end else if (ctl.load) begin
      diffR  <= $signed({1'b0, inPixel}) - $signed({1'b0, ctl.black});
      mantR  <= mantRom[ctl.mantIdx];
      shiftR <= ctl.shiftAmt;
      blackR <= ctl.black;
    end
  end

  logic signed [PROD_W-1:0] prod;
  logic signed [WIDE_W-1:0] scaled;
  logic signed [WIDE_W-1:0] sum;
  logic [DATA_W-1:0]        clipped;

  always_comb begin
    prod   = PROD_W'(diffR) * $signed({1'b0, mantR});
    scaled = (WIDE_W'(prod) <<< shiftR) >>> MANT_W;
    sum    = scaled + $signed({{(WIDE_W-DATA_W){1'b0}}, blackR});
    if (sum < 0)            clipped = '0;
    else if (sum > TOP_VAL) clipped = '1;
    else                    clipped = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outPixel <= '0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) outPixel <= clipped;
    end
  end

  assert_black_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.emit && diffR == '0) |=> outPixel == $past(blackR));
  assert_no_wrap_high_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.emit && !diffR[DIFF_W-1]) |=> outPixel >= $past(blackR));
  assert_no_wrap_low_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.emit && diffR[DIFF_W-1]) |=> outPixel <= $past(blackR));
endmodule

// File: rtl/dgain_db.sv
module dgain_db
  import dgain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inPixel,
  input  logic [DATA_W-1:0] blackLevel,
  input  logic [HI_W-1:0]   gainHi,
  input  logic [LO_W-1:0]   gainLo,
  output logic              outValid,
  output logic [DATA_W-1:0] outPixel
);
  dgCtrl_t ctl;

  dgain_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .gainHi(gainHi), .gainLo(gainLo), .blackLevel(blackLevel),
    .ctl(ctl)
  );

  dgain_datapath u_dp (
    .clk(clk), .rst(rst), .inPixel(inPixel), .ctl(ctl),
    .outValid(outValid), .outPixel(outPixel)
  );

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    $past(inValid) |=> outValid);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid) |=> !outValid);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outPixel));
endmodule

// File: tb/dgain_db_bench.sv
module dgain_db_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [11:0] inPixel = '0;
  logic [11:0] blackLevel = '0;
  logic [3:0] gainHi = 4'd3;
  logic [5:0] gainLo = '0;
  logic outValid;
  logic [11:0] outPixel;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit modelOn = 0;

  always #4 clk = ~clk;

  dgain_db u_dgain_db (
    .clk(clk), .rst(rst), .inValid(inValid), .inPixel(inPixel),
    .blackLevel(blackLevel), .gainHi(gainHi), .gainLo(gainLo),
    .outValid(outValid), .outPixel(outPixel)
  );

  function automatic int refOut(int pix, int code, int blk);
    int q = code / 192;
    int r = code % 192;
    longint m = longint'($rtoi((2.0 ** (real'(r) / 192.0)) * 32768.0 + 0.5));
    longint p = longint'(pix - blk) * m * (longint'(1) << q);
    longint s = (p >>> 16) + longint'(blk);
    if (s < 0) return 0;
    if (s > 4095) return 4095;
    return int'(s);
  endfunction

  // behavioural model, updated on each rising edge from the sampled inputs
  int mCode = 192, mBlack = 128;
  int mP1 = 0, mOut = 0;
  bit mV1 = 0, mOutV = 0;
  always @(posedge clk) begin
    if (rst) begin
      mCode = 192; mBlack = 128; mP1 = 0; mV1 = 0; mOut = 0; mOutV = 0;
    end else begin
      mOutV = mV1;
      if (mV1) mOut = mP1;
      mV1 = inValid;
      if (inValid) mP1 = refOut(int'(inPixel), mCode, mBlack);
      else begin
        mCode  = int'({gainHi, gainLo});
        mBlack = int'(blackLevel);
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && !rst) begin
      total++;
      if (outValid !== mOutV) begin
        bad++;
        $display("FAIL R6 outValid act=%0d exp=%0d", outValid, mOutV);
      end
      total++;
      if (int'(outPixel) !== mOut) begin
        bad++;
        $display("FAIL R1 outPixel act=%0d exp=%0d", outPixel, mOut);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(int hi, int lo, int blk);
    inValid = 1'b0;
    gainHi = 4'(hi); gainLo = 6'(lo); blackLevel = 12'(blk);
    @(negedge clk);
  endtask

  task automatic shot(int pix, int exp, string tag);
    inValid = 1'b1; inPixel = 12'(pix);
    @(negedge clk);
    chk("R6 early", int'(outValid), 0);
    inValid = 1'b0;
    @(negedge clk);
    chk("R6 valid", int'(outValid), 1);
    chk(tag, int'(outPixel), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 outValid", int'(outValid), 0);
    chk("R8 outPixel", int'(outPixel), 0);
    // first sample straight out of reset uses the reset setting: code 192, black 128
    rst = 1'b0;
    inValid = 1'b1; inPixel = 12'd1000; gainHi = 4'd15; gainLo = 6'd63; blackLevel = '0;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk("R8 reset code unity", int'(outPixel), 1000);
    modelOn = 1;

    setCfg(3, 0, 77);   shot(1234, 1234, "R2 unity");
    shot(5, 5, "R2 unity below black");
    setCfg(0, 0, 0);    shot(1000, 500, "R1 code 0 is -6 dB");
    setCfg(4, 0, 0);    shot(1000, 1259, "R9 hi=4 lo=0 code 256");
    setCfg(15, 63, 200); shot(200, 200, "R3 black fixed at max code");
    setCfg(0, 0, 200);  shot(200, 200, "R3 black fixed at min code");
    setCfg(15, 63, 0);  shot(4000, 4095, "R4 clip high");
    setCfg(15, 63, 300); shot(0, 0, "R5 clip low");

    // R7: change the setting in the middle of a run of samples
    setCfg(3, 0, 0);
    inValid = 1'b1; inPixel = 12'd1000; gainHi = 4'd15; gainLo = 6'd63; blackLevel = 12'd500;
    @(negedge clk);
    inPixel = 12'd2000;
    @(negedge clk);
    chk("R7 held code sample 1", int'(outPixel), 1000);
    inValid = 1'b0;
    @(negedge clk);
    chk("R7 held code sample 2", int'(outPixel), 2000);
    chk("R6 hold after run", int'(outPixel), 2000);

    // random stream, compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      inValid = ($urandom_range(3) != 0);
      inPixel = 12'($urandom);
      if ($urandom_range(7) == 0) begin
        gainHi = 4'($urandom); gainLo = 6'($urandom);
        blackLevel = 12'($urandom_range(400));
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule